// File: doc/BRIEF.md
# Iterative Rotation-Mode CORDIC Sine/Cosine Unit

This block rotates a two-dimensional fixed-point vector by a requested angle. It uses the shift-and-add CORDIC method and a single datapath stage that is reused once per iteration. A start pulse captures the initial x, y and angle values. A small controller then steps an iteration index through thirty micro-rotations. The index selects the arctangent constant and sets the arithmetic shift distance for each step.

Each of the three running values (x, y and residual angle z) is updated by one plain two-operand adder. A multiplexer in front of the adder's second input picks either the operand or its two's-complement negation. The adder itself therefore contains no subtract logic and can be replaced by an approximate or speculative adder without touching anything else.

A caller who wants cosine and sine loads y0 = 0 and x0 = the reciprocal of the accumulated CORDIC gain. The final x and y then carry cos z0 and sin z0 with no scaling step afterwards. Any other (x0, y0) yields the rotated vector multiplied by the CORDIC gain.

Top module: `cordic_rotator`

## Requirements
- R1: While reset is held and right after it is released, busy and done are low and xOut and yOut read zero.
- R2: A start pulse sampled while idle captures x0, y0 and z0, and busy is high from the following cycle.
- R3: Each micro-rotation moves z toward zero: when z is zero or positive the step uses direction +1 and z decreases; when z is negative the step uses direction -1 and z increases. Negative input angles therefore produce negative sines.
- R4: done rises at the 30th rising edge after the edge that accepted start, so exactly 30 micro-rotations run.
- R5: A start pulse that arrives while busy is ignored: the running computation and its result are unchanged, and no new run begins.
- R6: done is high for exactly one clock cycle per accepted start, and busy is low in that cycle.
- R7: While idle and start is low, xOut and yOut hold their last values whatever x0, y0 and z0 do.
- R8: All of x, y and z are 32-bit two's complement with 30 fraction bits, and z is in radians. With y0 = 0 and x0 = 0x26DD3B6A (about 0.607253), xOut and yOut equal cos z0 and sin z0 within 64 LSB for angles from 0 to 45 degrees.
- R9: For a general start vector, xOut = An(x0 cos z0 - y0 sin z0) and yOut = An(x0 sin z0 + y0 cos z0) within 64 LSB, where An is the product over i = 0..29 of sqrt(1 + 2^-2i).
- R10: Input angles anywhere from -89 to +89 degrees converge to the same accuracy as R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation; honoured only while idle |
| x0 | input | 32 | Initial x, Q2.30 |
| y0 | input | 32 | Initial y, Q2.30 |
| z0 | input | 32 | Rotation angle in radians, Q2.30 |
| busy | output | 1 | High while micro-rotations are running |
| done | output | 1 | One-cycle pulse when results are final |
| xOut | output | 32 | Rotated x (cosine term), Q2.30 |
| yOut | output | 32 | Rotated y (sine term), Q2.30 |

## Verification
Some properties hold on every cycle, and the assertions watch them there. A load copies the inputs into the registers one edge later. Every step moves the residual angle toward zero according to its sign. The registers do not move when neither load nor step is active. done lasts one cycle and arrives after exactly thirty running cycles. A start seen mid-run only advances the iteration index.

The bench's scenarios cover what no single-cycle property can show. They confirm that the final vectors match real-valued cosine and sine across the 0-45 degree range and for wider and negative angles. They show that a start issued mid-run leaves the result untouched. They also show that input changes while idle never reach the outputs.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  localparam int DATA_W = 32;
  localparam int FRAC_W = 30;
  localparam int ITERS  = 30;
  localparam int IDX_W  = $clog2(ITERS);

  // strobes issued by the controller to the datapath
  typedef struct packed {
    logic load;   // capture x0/y0/z0
    logic step;   // perform one micro-rotation
  } cordicStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } cordicState_t;

endpackage

// File: rtl/cordic_adder.sv
// Plain two-operand adder; the single place an approximate adder would go.
module cordic_adder #(
  parameter int W = cordic_pkg::DATA_W
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] sum
);
  always_comb sum = opA + opB;
endmodule

// File: rtl/cordic_addneg.sv
// Add-or-subtract built as: negation mux in front of a plain adder.
module cordic_addneg #(
  parameter int W = cordic_pkg::DATA_W
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] delta,
  input  logic         negate,
  output logic [W-1:0] result
);
  logic [W-1:0] deltaSel;

  always_comb deltaSel = negate ? (~delta + 1'b1) : delta;

  cordic_adder #(.W(W)) adder_i (
    .opA (base),
    .opB (deltaSel),
    .sum (result)
  );
endmodule

// File: rtl/cordic_ctrl.sv
module cordic_ctrl
  import cordic_pkg::*;
#(
  parameter int N_ITER = ITERS,
  parameter int IW     = IDX_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  output cordicStrobes_t strb,
  output logic [IW-1:0]  iterIdx,
  output logic           busy,
  output logic           done
);
  localparam logic [IW-1:0] LAST_IDX = IW'(N_ITER - 1);

  cordicState_t stateQ;
  logic [IW-1:0] idxQ;
  logic doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      idxQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (stateQ)
        ST_IDLE: begin
          if (start) begin
            stateQ <= ST_RUN;
            idxQ   <= '0;
          end
        end
        ST_RUN: begin
          if (idxQ == LAST_IDX) begin
            stateQ <= ST_IDLE;
            doneQ  <= 1'b1;
          end else begin
            idxQ <= idxQ + 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load = (stateQ == ST_IDLE) && start;
    strb.step = (stateQ == ST_RUN);
    iterIdx   = idxQ;
    busy      = (stateQ == ST_RUN);
    done      = doneQ;
  end

  // ---- assertions ----
  logic [IW:0] chkRunCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                 chkRunCnt <= '0;
    else if (strb.load)        chkRunCnt <= '0;
    else if (stateQ == ST_RUN) chkRunCnt <= chkRunCnt + 1'b1;
  end

  // R4: thirty running cycles precede done
  a_r4_run_length: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (chkRunCnt == (IW+1)'(N_ITER)));

  // R6: done is a single-cycle pulse, not overlapping busy
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R5: start mid-run only advances the index
  a_r5_ignore_start: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && idxQ != LAST_IDX) |=> (busy && idxQ == $past(idxQ) + 1'b1));

endmodule

// File: rtl/cordic_datapath.sv
module cordic_datapath
  import cordic_pkg::*;
#(
  parameter int W      = DATA_W,
  parameter int FW     = FRAC_W,
  parameter int N_ITER = ITERS,
  parameter int IW     = IDX_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  cordicStrobes_t      strb,
  input  logic [IW-1:0]       iterIdx,
  input  logic signed [W-1:0] x0,
  input  logic signed [W-1:0] y0,
  input  logic signed [W-1:0] z0,
  output logic signed [W-1:0] xOut,
  output logic signed [W-1:0] yOut
);
  localparam int ROM_DEPTH = 2 ** IW;
  localparam int SCALE_SH  = 62;

  // arctan(1/n) scaled by 2^62, series with integer division
  function automatic longint atanInvScaled(longint n);
    longint acc;
    longint pw;
    acc = 0;
    pw  = (longint'(1) <<< SCALE_SH) / n;
    for (int k = 0; k < 48; k++) begin
      if (pw != 0) begin
        if (k % 2 == 0) acc = acc + pw / longint'(2 * k + 1);
        else            acc = acc - pw / longint'(2 * k + 1);
        pw = pw / (n * n);
      end
    end
    return acc;
  endfunction

  // atan(2^-i) in the data format, rounded to nearest
  function automatic logic [W-1:0] atanConst(int i);
    longint full;
    if (i == 0) full = 4 * atanInvScaled(5) - atanInvScaled(239);
    else        full = atanInvScaled(longint'(1) <<< i);
    return W'((full + (longint'(1) <<< (SCALE_SH - FW - 1))) >>> (SCALE_SH - FW));
  endfunction

  logic [W-1:0] atanRom [ROM_DEPTH];

  for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_rom
    if (g < N_ITER) begin : g_used
      assign atanRom[g] = atanConst(g);
    end else begin : g_pad
      assign atanRom[g] = '0;
    end
  end

  logic signed [W-1:0] xQ, yQ, zQ;
  logic signed [W-1:0] xShift, yShift;
  logic [W-1:0] xNext, yNext, zNext;
  logic zNeg;

  always_comb begin
    zNeg   = zQ[W-1];
    xShift = xQ >>> iterIdx;
    yShift = yQ >>> iterIdx;
  end

  // x - d*(y>>i): subtract when d = +1 (z >= 0)
  cordic_addneg #(.W(W)) xUnit_i (
    .base   (xQ),
    .delta  (yShift),
    .negate (!zNeg),
    .result (xNext)
  );

  // y + d*(x>>i): subtract when d = -1 (z < 0)
  cordic_addneg #(.W(W)) yUnit_i (
    .base   (yQ),
    .delta  (xShift),
    .negate (zNeg),
    .result (yNext)
  );

  // z - d*atan(2^-i): subtract when d = +1
  cordic_addneg #(.W(W)) zUnit_i (
    .base   (zQ),
    .delta  (atanRom[iterIdx]),
    .negate (!zNeg),
    .result (zNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xQ <= '0;
      yQ <= '0;
      zQ <= '0;
    end else if (strb.load) begin
      xQ <= x0;
      yQ <= y0;
      zQ <= z0;
    end else if (strb.step) begin
      xQ <= xNext;
      yQ <= yNext;
      zQ <= zNext;
    end
  end

  assign xOut = xQ;
  assign yOut = yQ;

  // ---- assertions ----
  // R2: a load captures the inputs
  a_r2_load_capture: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (xQ == $past(x0) && yQ == $past(y0) && zQ == $past(z0)));

  // R3: non-negative residual angle shrinks
  a_r3_z_down: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !zQ[W-1]) |=> (zQ < $past(zQ)));

  // R3: negative residual angle grows
  a_r3_z_up: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && zQ[W-1]) |=> (zQ > $past(zQ)));

  // R7: without a strobe the results hold
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.step) |=> ($stable(xQ) && $stable(yQ)));

endmodule

// File: rtl/cordic_rotator.sv
module cordic_rotator
  import cordic_pkg::*;
#(
  parameter int W      = DATA_W,
  parameter int FW     = FRAC_W,
  parameter int N_ITER = ITERS,
  parameter int IW     = IDX_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic signed [W-1:0] x0,
  input  logic signed [W-1:0] y0,
  input  logic signed [W-1:0] z0,
  output logic                busy,
  output logic                done,
  output logic signed [W-1:0] xOut,
  output logic signed [W-1:0] yOut
);
  cordicStrobes_t strb;
  logic [IW-1:0] iterIdx;

  cordic_ctrl #(.N_ITER(N_ITER), .IW(IW)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strb    (strb),
    .iterIdx (iterIdx),
    .busy    (busy),
    .done    (done)
  );

  cordic_datapath #(.W(W), .FW(FW), .N_ITER(N_ITER), .IW(IW)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .iterIdx (iterIdx),
    .x0      (x0),
    .y0      (y0),
    .z0      (z0),
    .xOut    (xOut),
    .yOut    (yOut)
  );

endmodule

// File: tb/cordic_rotator_tb_top.sv
module cordic_rotator_tb_top;

  localparam int    W    = 32;
  localparam int    N    = 30;
  localparam real   ONE  = 1073741824.0;   // 2^30
  localparam real   PI   = 3.14159265358979323846;
  localparam longint TOL = 64;
  localparam logic signed [W-1:0] INV_GAIN = 32'sh26DD3B6A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic signed [W-1:0] x0 = '0, y0 = '0, z0 = '0;
  logic busy, done;
  logic signed [W-1:0] xOut, yOut;

  always #5 clk = ~clk;

  cordic_rotator dut_i (
    .clk (clk), .rstN (rstN), .start (start),
    .x0 (x0), .y0 (y0), .z0 (z0),
    .busy (busy), .done (done), .xOut (xOut), .yOut (yOut)
  );

  typedef struct {
    longint ex;
    longint ey;
    string  tag;
  } expItem_t;

  expItem_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  real gainAn;
  logic finished = 1'b0;

  function automatic longint toFix(real r);
    return longint'($rtoi(r * ONE + ((r >= 0.0) ? 0.5 : -0.5)));
  endfunction

  task automatic check(string req, longint act, longint expv, longint tol);
    longint diff;
    diff = act - expv;
    if (diff < 0) diff = -diff;
    nChecks++;
    if (diff > tol) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // monitor: pops expectations when done pulses
  logic prevDone = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevDone && done) check("R6 done width", 1, 0, 0);
      if (done) begin
        check("R6 busy low with done", longint'(busy), 0, 0);
        if (expQ.size() == 0) begin
          check("R5 unexpected done", 1, 0, 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check({it.tag, " x"}, longint'(xOut), it.ex, TOL);
          check({it.tag, " y"}, longint'(yOut), it.ey, TOL);
        end
      end
    end
    prevDone <= done;
  end

  // driver: push expectation, pulse start, measure latency
  task automatic runVec(real xr, real yr, real deg, string tag, bit midStart);
    real a;
    expItem_t it;
    int cnt;
    a = deg * PI / 180.0;
    it.ex = toFix(gainAn * (xr * $cos(a) - yr * $sin(a)));
    it.ey = toFix(gainAn * (xr * $sin(a) + yr * $cos(a)));
    it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    x0 = W'(toFix(xr)); y0 = W'(toFix(yr)); z0 = W'(toFix(a));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    check("R2 busy after start", longint'(busy), 1, 0);
    while (!done) begin
      if (midStart && cnt == 6) begin
        // R5: restart attempt with different operands while busy
        x0 = W'(toFix(0.9)); y0 = W'(toFix(-0.4)); z0 = W'(toFix(-1.0));
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    check("R4 latency", longint'(cnt), 31, 0);
  endtask

  initial begin
    gainAn = 1.0;
    for (int i = 0; i < N; i++) gainAn = gainAn * $sqrt(1.0 + 2.0 ** (-2.0 * i));

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 busy in reset", longint'(busy), 0, 0);
    check("R1 done in reset", longint'(done), 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", longint'(busy), 0, 0);
    check("R1 xOut after reset", longint'(xOut), 0, 0);
    check("R1 yOut after reset", longint'(yOut), 0, 0);

    // R8: cos/sin over 0..45 degrees
    for (int d = 0; d <= 45; d += 5) begin
      runVec(real'(INV_GAIN) / ONE, 0.0, real'(d), "R8 cos/sin", 1'b0);
    end

    // R9: general vectors
    runVec(0.5, 0.25, 30.0, "R9 general", 1'b0);
    runVec(0.2, -0.1, 60.0, "R9 general", 1'b0);

    // R3 / R10: negative and wide angles
    runVec(real'(INV_GAIN) / ONE, 0.0, -30.0, "R3 negative angle", 1'b0);
    runVec(-0.3, 0.4, -60.0, "R10 wide negative", 1'b0);
    runVec(0.2, -0.1, 89.0, "R10 wide positive", 1'b0);
    runVec(0.1, 0.1, -89.0, "R10 wide negative", 1'b0);

    // R5: start while busy ignored
    runVec(real'(INV_GAIN) / ONE, 0.0, 20.0, "R5 mid-run start", 1'b1);
    repeat (2) @(negedge clk);
    check("R5 no second run", longint'(busy), 0, 0);

    // R7: idle outputs hold while inputs change
    begin
      longint hx, hy;
      hx = longint'(xOut); hy = longint'(yOut);
      x0 = W'(toFix(-0.7)); y0 = W'(toFix(0.6)); z0 = W'(toFix(1.2));
      repeat (5) @(negedge clk);
      check("R7 xOut held", longint'(xOut), hx, 0);
      check("R7 yOut held", longint'(yOut), hy, 0);
      check("R7 stays idle", longint'(busy), 0, 0);
    end

    repeat (3) @(negedge clk);
    check("R6 all results delivered", longint'(expQ.size()), 0, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule